// File: doc/BRIEF.md
# Guarded CAN Clock-Source Select Register

This block is the module-level control register of a multi-node CAN controller. It sits on a simple register bus and holds the clock-source select for the baud-rate logic. It also holds one init bit for each CAN node. Software reads and writes it through an address, write enable, byte enables and write data, and reads it back through a read-data port. Each node supplies a configuration-enable input.

The low byte of the control word holds the 2-bit clock-source field. A write to that byte always forces every node back into init. The write changes the field only while every node has its configuration enable raised.

A source change is a two-step sequence. Software first writes zero, which means no clock. It then writes the new nonzero source. Between the two writes a per-source settle interval has to pass. An internal down-counter measures that interval in module-clock cycles, and a busy flag reports it. The block rejects a direct jump between two nonzero sources, and it rejects a new source written while the counter is still running. Either case sets a sticky sequence-error flag.

Register layout, word addresses:
- Address 0, control word:
  - bits [1:0]: clock source, read/write, gated.
  - bit 8: busy, read only.
  - bit 9: sequence error. Writing 1 clears it, and the write counts only when byte lane 1 is enabled.
- Address 1, node init word: bits [NODES-1:0] hold one init bit per node. A write with byte lane 0 enabled loads them.
- Any other address reads as zero.

Top module: `can_clksel_ctrl`

## Requirements
- R1: A write to address 0 with byte enable 0 set changes the clock-source field only if every `cfg_en` bit is 1. Otherwise `clk_sel` keeps its value.
- R2: Every write to address 0 with byte enable 0 set drives all `node_init` bits to 1 on the next cycle. This holds whatever the state of `cfg_en`.
- R3: `node_init` changes only on a write of the kind in R2, or on a write to address 1 with byte enable 0 set. The address-1 write loads `reg_wdata[NODES-1:0]`. In every other cycle the bits hold.
- R4: A gated write of 0 while the field is nonzero sets `clk_sel` to 0 on the next cycle. It also loads the settle counter with the count of the outgoing source: SETTLE_SRC1, SETTLE_SRC2 or SETTLE_SRC3.
- R5: A gated nonzero write while the field is 0 and busy is clear puts the new value on `clk_sel` on the next cycle.
- R6: A gated nonzero write that differs from a nonzero field is rejected. `clk_sel` keeps its value and the sequence-error bit (address 0, bit 9) is set.
- R7: A gated nonzero write while busy is set is dropped. `clk_sel` stays 0 and the sequence-error bit is set.
- R8: When the outgoing source is encoding 1 (default count 0), busy stays clear. A nonzero write in the cycle right after the zero write is then accepted.
- R9: The sequence-error bit stays set until a write to address 0 with byte enable 1 set and `reg_wdata[9]`=1. If the same write also raises an error, the set wins.
- R10: Busy (address 0, bit 8) reads 1 for exactly the loaded count of cycles after the zero write, then reads 0. Reads of address 0 return {error, busy, field} at bits 9, 8 and 1:0. Reads of address 1 return the init bits.
- R11: Reset, asynchronous and active low, sets `clk_sel` to 0 and all `node_init` bits to 1, and clears busy and the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_be | input | DATA_W/8 | Byte enables |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| cfg_en | input | NODES | Configuration enable, one bit per node |
| node_init | output | NODES | Init request, one bit per node |
| clk_sel | output | 2 | Clock source to the baud-rate logic, 0 meaning none |

## Verification
The bench drives the block through the ways a source change can go wrong:
- A jump between two nonzero sources. A design that let it through would switch the baud-rate clock without a stop.
- A second write while the counter still runs. A design that missed it would start the new clock too early.
- A low-byte write with one configuration enable low. It has to leave the field alone but still push every node into init. A design that gated the init forcing together with the field would leave nodes running through a clock change.
- A stop from encoding 1 followed at once by a new source. A design with an off-by-one in the counter would refuse this write, or would accept a write one cycle too soon after the other sources.
- A write that both clears and raises the error. This checks that the error flag is sticky and that the set wins.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
    typedef logic [1:0] clksel_t;

    localparam clksel_t CLKSEL_NONE = 2'd0;
    localparam int      ADDR_CTRL   = 0;
    localparam int      ADDR_NODE   = 1;
    localparam int      BUSY_BIT    = 8;
    localparam int      ERR_BIT     = 9;
endpackage

// File: rtl/ccs_wr_decode.sv
`timescale 1ns/1ps
module ccs_wr_decode #(
    parameter int NODES  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [NODES-1:0]    cfg_en,
    output logic                ctrl_lo_wr,
    output logic                ctrl_lo_ok,
    output logic                err_clr,
    output logic                node_wr
);
    import ccs_pkg::*;

    logic hit_ctrl;
    logic hit_node;

    always_comb begin
        hit_ctrl   = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
        hit_node   = reg_we && (reg_addr == ADDR_W'(ADDR_NODE));
        ctrl_lo_wr = hit_ctrl && reg_be[0];
        ctrl_lo_ok = ctrl_lo_wr && (&cfg_en);
        err_clr    = hit_ctrl && reg_be[1] && reg_wdata[ERR_BIT];
        node_wr    = hit_node && reg_be[0];
    end
endmodule

// File: rtl/ccs_settle_timer.sv
`timescale 1ns/1ps
module ccs_settle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/can_clksel_ctrl.sv
`timescale 1ns/1ps
module can_clksel_ctrl #(
    parameter int NODES       = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SETTLE_SRC1 = 0,
    parameter int SETTLE_SRC2 = 6,
    parameter int SETTLE_SRC3 = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NODES-1:0]    cfg_en,
    output logic [NODES-1:0]    node_init,
    output logic [1:0]          clk_sel
);
    import ccs_pkg::*;

    localparam int MAX12     = (SETTLE_SRC1 > SETTLE_SRC2) ? SETTLE_SRC1 : SETTLE_SRC2;
    localparam int SETTLE_MX = (MAX12 > SETTLE_SRC3) ? MAX12 : SETTLE_SRC3;
    localparam int CNT_W     = $clog2(SETTLE_MX + 2);

    typedef struct packed {
        clksel_t          sel;
        logic [NODES-1:0] init;
        logic             err;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             ctrl_lo_wr, ctrl_lo_ok, err_clr, node_wr;
    logic             settle_busy;
    logic             settle_load;
    logic [CNT_W-1:0] settle_val;
    logic             seq_err;
    clksel_t          req_sel;

    ccs_wr_decode #(
        .NODES (NODES),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dec (
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .cfg_en    (cfg_en),
        .ctrl_lo_wr(ctrl_lo_wr),
        .ctrl_lo_ok(ctrl_lo_ok),
        .err_clr   (err_clr),
        .node_wr   (node_wr)
    );

    ccs_settle_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .load_val(settle_val),
        .busy    (settle_busy)
    );

    // Settle count of the source that is being switched off.
    always_comb begin
        case (st_q.sel)
            2'd1:    settle_val = CNT_W'(SETTLE_SRC1);
            2'd2:    settle_val = CNT_W'(SETTLE_SRC2);
            2'd3:    settle_val = CNT_W'(SETTLE_SRC3);
            default: settle_val = '0;
        endcase
    end

    always_comb begin
        logic bad_seq;
        st_d        = st_q;
        settle_load = 1'b0;
        bad_seq     = 1'b0;
        req_sel     = reg_wdata[1:0];

        // Any low-byte write parks every node in init; node word loads otherwise.
        if (ctrl_lo_wr) begin
            st_d.init = '1;
        end else if (node_wr) begin
            st_d.init = reg_wdata[NODES-1:0];
        end

        if (ctrl_lo_ok) begin
            if (req_sel == CLKSEL_NONE) begin
                if (st_q.sel != CLKSEL_NONE) begin
                    st_d.sel    = CLKSEL_NONE;
                    settle_load = 1'b1;
                end
            end else if (st_q.sel == CLKSEL_NONE) begin
                if (settle_busy) bad_seq = 1'b1;
                else             st_d.sel = req_sel;
            end else if (req_sel != st_q.sel) begin
                bad_seq = 1'b1;
            end
        end

        if (err_clr) st_d.err = 1'b0;
        if (bad_seq) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= CLKSEL_NONE;
            st_q.init <= '1;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[1:0]      = st_q.sel;
            reg_rdata[BUSY_BIT] = settle_busy;
            reg_rdata[ERR_BIT]  = st_q.err;
        end else if (reg_addr == ADDR_W'(ADDR_NODE)) begin
            reg_rdata[NODES-1:0] = st_q.init;
        end
    end

    assign seq_err   = st_q.err;
    assign node_init = st_q.init;
    assign clk_sel   = st_q.sel;
endmodule

// File: rtl/ccs_checker.sv
`timescale 1ns/1ps
module ccs_checker #(
    parameter int NODES  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_we,
    input logic [DATA_W/8-1:0] reg_be,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [NODES-1:0]    cfg_en,
    input logic [NODES-1:0]    node_init,
    input logic [1:0]          clk_sel,
    input logic                busy,
    input logic                err
);
    logic lo_wr, lo_ok, init_wr, clr_wr;
    assign lo_wr   = reg_we && (reg_addr == ADDR_W'(0)) && reg_be[0];
    assign lo_ok   = lo_wr && (&cfg_en);
    assign init_wr = lo_wr || (reg_we && (reg_addr == ADDR_W'(1)) && reg_be[0]);
    assign clr_wr  = reg_we && (reg_addr == ADDR_W'(0)) && reg_be[1] && reg_wdata[9];

    AST_SEL_HOLD_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_ok |=> $stable(clk_sel)); // R1
    AST_INIT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (&node_init)); // R2
    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !init_wr |=> $stable(node_init)); // R3
    AST_BUSY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (clk_sel == 2'd0)); // R4
    AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != 2'd0) |=> (clk_sel == 2'd0) || $stable(clk_sel)); // R6
    AST_HOLD_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (clk_sel == 2'd0)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_wr) |=> err); // R9
endmodule

bind can_clksel_ctrl ccs_checker #(
    .NODES (NODES),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_ccs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_be   (reg_be),
    .reg_wdata(reg_wdata),
    .cfg_en   (cfg_en),
    .node_init(node_init),
    .clk_sel  (clk_sel),
    .busy     (settle_busy),
    .err      (seq_err)
);

// File: tb/tb_can_clksel_ctrl.sv
`timescale 1ns/1ps
module tb_can_clksel_ctrl;
    localparam int NODES = 4, ADDR_W = 4, DATA_W = 32;
    localparam int S1 = 0, S2 = 6, S3 = 9;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic                reg_we = 1'b0;
    logic [DATA_W/8-1:0] reg_be = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic [DATA_W-1:0]   reg_rdata;
    logic [NODES-1:0]    cfg_en = '1;
    logic [NODES-1:0]    node_init;
    logic [1:0]          clk_sel;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    can_clksel_ctrl #(.NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SETTLE_SRC1(S1), .SETTLE_SRC2(S2), .SETTLE_SRC3(S3)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_en(cfg_en), .node_init(node_init), .clk_sel(clk_sel));

    always #10 clk = ~clk;

    // Behavioural reference model
    int m_sel = 0, m_cnt = 0, m_err = 0;
    int m_init = 15;

    function automatic int settle_of(int s);
        return (s == 1) ? S1 : (s == 2) ? S2 : (s == 3) ? S3 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 0; m_cnt = 0; m_err = 0; m_init = 15;
        end else begin
            int nsel, ncnt, nerr, ninit, v;
            bit wctl, lo, ok, bad;
            wctl  = reg_we && reg_addr == 0;
            lo    = wctl && reg_be[0];
            ok    = lo && (cfg_en == 4'hF);
            nsel  = m_sel; nerr = m_err; ninit = m_init;
            ncnt  = (m_cnt > 0) ? m_cnt - 1 : 0;
            bad   = 0;
            v     = int'(reg_wdata[1:0]);
            if (lo) ninit = 15;
            else if (reg_we && reg_addr == 1 && reg_be[0]) ninit = int'(reg_wdata[3:0]);
            if (ok) begin
                if (v == 0) begin
                    if (m_sel != 0) begin nsel = 0; ncnt = settle_of(m_sel); end
                end else if (m_sel == 0) begin
                    if (m_cnt > 0) bad = 1; else nsel = v;
                end else if (v != m_sel) bad = 1;
            end
            if (wctl && reg_be[1] && reg_wdata[9]) nerr = 0;
            if (bad) nerr = 1;
            m_sel = nsel; m_cnt = ncnt; m_err = nerr; m_init = ninit;
        end
    end

    task automatic chk(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t got %0d expected %0d", tag, $time, got, exp);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        int exp_rd;
        if (!done) begin
            cycles++;
            chk("R4/R5/R6 clk_sel", int'(clk_sel), m_sel);
            chk("R2/R3 node_init", int'(node_init), m_init);
            if (reg_addr == 0) exp_rd = (m_err << 9) | ((m_cnt > 0) << 8) | m_sel;
            else if (reg_addr == 1) exp_rd = m_init;
            else exp_rd = 0;
            chk("R10 reg_rdata", int'(reg_rdata), exp_rd);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            reg_we = 0;
        end
    endtask

    task automatic wr(int a, logic [3:0] be, int d);
        @(posedge clk); #2;
        reg_we = 1; reg_addr = ADDR_W'(a); reg_be = be; reg_wdata = DATA_W'(d);
        @(posedge clk); #2;
        reg_we = 0; reg_addr = '0;
    endtask

    task automatic rd_now(string tag, int a, int exp);
        @(posedge clk); #2;
        reg_we = 0; reg_addr = ADDR_W'(a);
        #5 chk(tag, int'(reg_rdata), exp);
    endtask

    initial begin
        #25;
        // R11: reset state
        chk("R11 clk_sel reset", int'(clk_sel), 0);
        chk("R11 node_init reset", int'(node_init), 15);
        chk("R11 ctrl read reset", int'(reg_rdata), 0);
        @(posedge clk); #2 rst_n = 1;
        idle(2);
        wr(1, 4'b0001, 0);                       // R3: software clears init
        rd_now("R3 init cleared", 1, 0);
        cfg_en = 4'b1011;
        wr(0, 4'b0001, 2);                       // R1 gated off, R2 still forces init
        rd_now("R1 sel unchanged", 0, 0);
        rd_now("R2 init forced", 1, 15);
        cfg_en = 4'hF;
        wr(1, 4'b0001, 5);
        wr(0, 4'b0010, 0);                       // R3: byte1 only, no init forcing
        rd_now("R3 init held", 1, 5);
        wr(0, 4'b0001, 2);                       // R5
        rd_now("R5 sel=2", 0, 2);
        wr(0, 4'b0001, 3);                       // R6 direct switch
        rd_now("R6 rejected+err", 0, (1 << 9) | 2);
        wr(0, 4'b0011, 32'h200 | 3);             // R9 clear and raise together: set wins
        rd_now("R9 set wins", 0, (1 << 9) | 2);
        wr(0, 4'b0010, 32'h200);                 // R9 clear
        rd_now("R9 cleared", 0, 2);
        wr(0, 4'b0001, 0);                       // R4 stop source 2
        rd_now("R10 busy", 0, (1 << 8));
        wr(0, 4'b0001, 3);                       // R7 while busy
        rd_now("R7 dropped+err", 0, (1 << 9) | (1 << 8));
        idle(8);
        rd_now("R10 busy done", 0, (1 << 9));
        wr(0, 4'b0011, 32'h200 | 3);             // clear err, accept 3
        rd_now("R5 sel=3", 0, 3);
        wr(0, 4'b0001, 0);
        idle(12);
        wr(0, 4'b0001, 1);
        rd_now("R5 sel=1", 0, 1);
        // R8: from source 1 no wait, second write on the very next cycle
        @(posedge clk); #2;
        reg_we = 1; reg_addr = 0; reg_be = 4'b0001; reg_wdata = 0;
        @(posedge clk); #2;
        reg_wdata = 2;
        @(posedge clk); #2;
        reg_we = 0;
        rd_now("R8 immediate accept", 0, 2);
        wr(0, 4'b0001, 0);
        idle(3);
        @(posedge clk); #2 rst_n = 0;            // R11 mid-run
        #5 chk("R11 reset mid-run", int'(clk_sel), 0);
        @(posedge clk); #2 rst_n = 1;
        idle(3);
        rd_now("R11 busy cleared", 0, 0);
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired got %0d expected 0", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule